// File: doc/BRIEF.md
# Keep-Alive Supervision Chain Monitor

This block watches a stack of subordinate processors, each of which must keep
changing a keep-alive word to prove that it is still running. On every pulse of
a shared check strobe, each supervised level compares its current word with the
word it saw at the previous accepted strobe. A changed word counts as proof of
life and clears that level's miss counter. An unchanged word counts as one
missed update. When the misses reach a programmable limit, the level latches a
safe-mode request. The request stays latched until a per-level clear is pulsed,
even if the subordinate starts updating its word again.

The levels form a hierarchy. Level 0 is the top supervisor, and each higher
index sits one step further down the chain. Each level's safe request output is
the OR of its own latched trip and the trips of every level above it. When an
upper level safes, every level below it is forced to safe as well. Each level
has its own enable. While a level is disabled it does not count misses. A trip
that is already latched stays latched while the level is disabled.

Top module: `keepalive_chain_supervisor`

## Requirements
- R1: After reset every bit of `safe_req_o` is 0.
- R2: The first accepted strobe after reset, after a clear, or after the level's enable rises only captures the keep-alive word. It never counts a miss, whatever the word value.
- R3: A strobe on which a primed level sees a word that differs from its captured word resets that level's miss count to zero. A level whose word changes on every strobe never trips.
- R4: A strobe on which a primed level sees an unchanged word adds one miss. When the miss count reaches the level's limit, the trip latches on that clock edge and shows on `safe_req_o` in the same cycle. With limit L, L-1 stuck strobes leave the level untripped.
- R5: A limit field of 0 selects the default limit of 2 missed updates.
- R6: A latched trip stays set when keep-alive activity resumes. Only that level's clear removes it.
- R7: A clear has priority over a strobe in the same cycle. It removes the level's trip, zeroes its miss count and un-primes the level.
- R8: `safe_req_o[i]` is 1 when level i or any level j < i has a latched trip. Level 0 is the top of the chain.
- R9: A disabled level counts no misses, and its miss count and primed state are cleared. A trip that is already latched is kept while the level is disabled.
- R10: Cycles without a check strobe leave every miss count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_stb_i | input | 1 | Check strobe shared by all levels, one cycle per check |
| sup_en_i | input | LEVELS | Per-level supervision enable |
| ka_word_i | input | LEVELS*KW | Keep-alive words. Level i uses bits [i*KW +: KW] |
| miss_limit_i | input | LEVELS*CW | Per-level miss limit in strobes, bits [i*CW +: CW]. A value of 0 selects the default |
| clr_i | input | LEVELS | Per-level clear of the latched trip |
| safe_req_o | output | LEVELS | Cascaded safe-mode request per level |

## Verification
The bench drives a level that stops at exactly one strobe short of its limit, then one strobe past it. A design that trips one strobe early or one strobe late is caught at that edge. It fires a clear and a strobe in the same cycle, and holds the word constant across the capture strobe right after a clear or a re-enable. A design that compares against a stale sample or lets the strobe win would trip at the wrong point. The bench also resumes activity on a tripped level to catch a trip that self-releases. It leaves long gaps with no strobe to catch a counter that ticks on plain cycles. It disables a tripped top level to show that the whole chain below keeps its forced request and drops only on clear.

// File: rtl/kas_pkg.sv
package kas_pkg;

  // Outcome of one cycle of keep-alive observation for one level.
  typedef enum logic [1:0] {
    KAS_EV_NONE  = 2'd0,   // nothing to account for
    KAS_EV_ALIVE = 2'd1,   // strobe saw a new word
    KAS_EV_MISS  = 2'd2,   // strobe saw the same word again
    KAS_EV_REARM = 2'd3    // level disabled or cleared: forget history
  } kas_ev_e;

  localparam int unsigned KAS_DEF_LIMIT = 2;

endpackage

// File: rtl/kas_change_det.sv
module kas_change_det
  import kas_pkg::*;
#(
  parameter int unsigned KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [KW-1:0] word_i,
  output kas_ev_e       ev_o
);

  logic [KW-1:0] last_q, last_n;
  logic          primed_q, primed_n;
  kas_ev_e       ev_n;

  always_comb begin
    last_n   = last_q;
    primed_n = primed_q;
    ev_n     = KAS_EV_NONE;
    if (clr_i || !en_i) begin
      primed_n = 1'b0;
      ev_n     = KAS_EV_REARM;
    end else if (stb_i) begin
      if (!primed_q) begin
        primed_n = 1'b1;
        last_n   = word_i;
      end else if (word_i != last_q) begin
        last_n = word_i;
        ev_n   = KAS_EV_ALIVE;
      end else begin
        ev_n = KAS_EV_MISS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      last_q   <= last_n;
      primed_q <= primed_n;
    end
  end

  assign ev_o = ev_n;

  // R2
  capture_primes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && en_i && !clr_i && !primed_q) |-> (ev_o == KAS_EV_NONE) ##1 primed_q);

  // R2
  unprimed_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (ev_o != KAS_EV_MISS));

endmodule

// File: rtl/kas_miss_timer.sv
module kas_miss_timer
  import kas_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned DEF_LIMIT = KAS_DEF_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  kas_ev_e       ev_i,
  input  logic [CW-1:0] limit_i,
  output logic          trip_o
);

  localparam logic [CW-1:0] DEF_LIM_V = CW'(DEF_LIMIT);
  localparam logic [CW-1:0] CNT_MAX   = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_n, cnt_inc, eff_lim;
  logic          trip_q, trip_n;
  logic          cnt_en;

  assign eff_lim = (limit_i == '0) ? DEF_LIM_V : limit_i;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign cnt_en  = clr_i || (ev_i != KAS_EV_NONE);

  always_comb begin
    cnt_n  = cnt_q;
    trip_n = trip_q;
    if (clr_i) begin
      cnt_n  = '0;
      trip_n = 1'b0;
    end else begin
      unique case (ev_i)
        KAS_EV_REARM,
        KAS_EV_ALIVE: cnt_n = '0;
        KAS_EV_MISS: begin
          cnt_n = cnt_inc;
          if (cnt_inc >= eff_lim) trip_n = 1'b1;
        end
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_n;
      trip_q <= trip_n;
    end
  end

  assign trip_o = trip_q;

  // R6
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr_i) |=> trip_q);

  // R7
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!trip_q && cnt_q == '0));

  // R3
  alive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == KAS_EV_ALIVE && !clr_i) |=> (cnt_q == '0));

  // R4
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(ev_i == KAS_EV_MISS));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == KAS_EV_NONE && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kas_cascade.sv
module kas_cascade #(
  parameter int unsigned LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] trip_i,
  output logic [LEVELS-1:0] safe_o
);

  assign safe_o[0] = trip_i[0];

  for (genvar g = 1; g < LEVELS; g++) begin : g_chain
    assign safe_o[g] = trip_i[g] | safe_o[g-1];

    // R8
    downward_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      safe_o[g-1] |-> safe_o[g]);
  end

  // R8
  own_trip_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((safe_o & trip_i) == trip_i));

endmodule

// File: rtl/keepalive_chain_supervisor.sv
module keepalive_chain_supervisor
  import kas_pkg::*;
#(
  parameter int unsigned LEVELS    = 4,
  parameter int unsigned KW        = 8,
  parameter int unsigned CW        = 8,
  parameter int unsigned DEF_LIMIT = KAS_DEF_LIMIT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_stb_i,
  input  logic [LEVELS-1:0]    sup_en_i,
  input  logic [LEVELS*KW-1:0] ka_word_i,
  input  logic [LEVELS*CW-1:0] miss_limit_i,
  input  logic [LEVELS-1:0]    clr_i,
  output logic [LEVELS-1:0]    safe_req_o
);

  logic [LEVELS-1:0] trip;

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    kas_ev_e ev;

    kas_change_det #(.KW(KW)) i_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (chk_stb_i),
      .en_i   (sup_en_i[g]),
      .clr_i  (clr_i[g]),
      .word_i (ka_word_i[g*KW +: KW]),
      .ev_o   (ev)
    );

    kas_miss_timer #(.CW(CW), .DEF_LIMIT(DEF_LIMIT)) i_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i[g]),
      .ev_i    (ev),
      .limit_i (miss_limit_i[g*CW +: CW]),
      .trip_o  (trip[g])
    );

    // R9
    disabled_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_en_i[g] |=> !$rose(trip[g]));
  end

  kas_cascade #(.LEVELS(LEVELS)) i_cascade (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (trip),
    .safe_o (safe_req_o)
  );

endmodule

// File: tb/test_keepalive_chain_supervisor.sv
`timescale 1ns/1ps
module test_keepalive_chain_supervisor;

  localparam int L  = 4;
  localparam int KW = 8;
  localparam int CW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            chk_stb_i;
  logic [L-1:0]    sup_en_i;
  logic [L*KW-1:0] ka_word_i;
  logic [L*CW-1:0] miss_limit_i;
  logic [L-1:0]    clr_i;
  logic [L-1:0]    safe_req_o;

  keepalive_chain_supervisor #(.LEVELS(L), .KW(KW), .CW(CW)) i_keepalive_chain_supervisor (
    .clk(clk), .rst_n(rst_n), .chk_stb_i(chk_stb_i), .sup_en_i(sup_en_i),
    .ka_word_i(ka_word_i), .miss_limit_i(miss_limit_i), .clr_i(clr_i),
    .safe_req_o(safe_req_o)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R1";
  logic [L-1:0] live;

  // behavioural reference state
  int m_trip [L];
  int m_cnt  [L];
  int m_prim [L];
  int m_last [L];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) begin
        m_trip[i] = 0; m_cnt[i] = 0; m_prim[i] = 0; m_last[i] = 0;
      end
    end else begin
      for (int i = 0; i < L; i++) begin
        int w, lim;
        w   = int'(ka_word_i[i*KW +: KW]);
        lim = int'(miss_limit_i[i*CW +: CW]);
        if (lim == 0) lim = 2;
        if (clr_i[i]) begin
          m_trip[i] = 0; m_cnt[i] = 0; m_prim[i] = 0;
        end else if (!sup_en_i[i]) begin
          m_cnt[i] = 0; m_prim[i] = 0;
        end else if (chk_stb_i) begin
          if (m_prim[i] == 0) begin
            m_prim[i] = 1; m_last[i] = w;
          end else if (w != m_last[i]) begin
            m_last[i] = w; m_cnt[i] = 0;
          end else begin
            if (m_cnt[i] < 255) m_cnt[i]++;
            if (m_cnt[i] >= lim) m_trip[i] = 1;
          end
        end
      end
    end
  end

  function automatic logic [L-1:0] model_safe();
    logic [L-1:0] r;
    int acc = 0;
    for (int i = 0; i < L; i++) begin
      if (m_trip[i] != 0) acc = 1;
      r[i] = (acc != 0);
    end
    return r;
  endfunction

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (safe_req_o !== model_safe()) begin
        n_bad++;
        $display("FAIL %s cycle %0d: safe_req_o=%b expected %b", tag, cyc, safe_req_o, model_safe());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: expired at cycle %0d, expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic expect_mask(input logic [L-1:0] exp, input string t);
    n_chk++;
    if (safe_req_o !== exp) begin
      n_bad++;
      $display("FAIL %s directed: safe_req_o=%b expected %b", t, safe_req_o, exp);
    end
  endtask

  // one strobe; live levels get a new word; optional clear in the same cycle
  task automatic strobe(input logic [L-1:0] clr_mask);
    @(negedge clk);
    for (int i = 0; i < L; i++)
      if (live[i]) ka_word_i[i*KW +: KW] = ka_word_i[i*KW +: KW] + 8'd1;
    chk_stb_i = 1'b1;
    clr_i     = clr_mask;
    @(negedge clk);
    chk_stb_i = 1'b0;
    clr_i     = '0;
    @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) strobe('0);
  endtask

  task automatic clear(input logic [L-1:0] m);
    @(negedge clk);
    clr_i = m;
    @(negedge clk);
    clr_i = '0;
  endtask

  initial begin
    rst_n = 1'b0; chk_stb_i = 1'b0; sup_en_i = '0; ka_word_i = '0;
    miss_limit_i = '0; clr_i = '0; live = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; expect_mask(4'b0000, "R1");

    tag = "R3"; sup_en_i = '1;
    strobes(10);
    expect_mask(4'b0000, "R3");

    tag = "R10"; live = '0;
    repeat (30) @(negedge clk);
    live = '1; strobes(3);
    expect_mask(4'b0000, "R10");

    tag = "R5"; live = 4'b1011;
    strobes(1); expect_mask(4'b0000, "R5");
    strobes(1); expect_mask(4'b1100, "R5");
    tag = "R8"; expect_mask(4'b1100, "R8");

    tag = "R6"; live = '1;
    strobes(3); expect_mask(4'b1100, "R6");

    tag = "R7"; strobe(4'b0100);
    expect_mask(4'b0000, "R7");
    tag = "R2"; live = 4'b1011;
    strobes(1); expect_mask(4'b0000, "R2");
    strobes(1); expect_mask(4'b0000, "R2");
    strobes(1); expect_mask(4'b1100, "R4");
    clear(4'b0100); live = '1;
    strobes(2);

    tag = "R4"; miss_limit_i[3*CW +: CW] = 8'd5; live = 4'b0111;
    strobes(4); expect_mask(4'b0000, "R4");
    strobes(1); expect_mask(4'b1000, "R4");
    clear(4'b1000); live = '1; miss_limit_i = '0;
    strobes(2);

    tag = "R9"; sup_en_i = 4'b1101; live = 4'b1101;
    strobes(6); expect_mask(4'b0000, "R9");
    sup_en_i = '1;
    tag = "R2"; strobes(1); expect_mask(4'b0000, "R2");
    strobes(1); expect_mask(4'b0000, "R2");
    strobes(1); expect_mask(4'b1110, "R8");
    clear(4'b0010); live = '1;
    strobes(2); expect_mask(4'b0000, "R7");

    tag = "R8"; live = 4'b1110;
    strobes(2); expect_mask(4'b1111, "R8");
    tag = "R9"; sup_en_i = 4'b1110;
    strobes(3); expect_mask(4'b1111, "R9");
    clear(4'b0001); @(negedge clk);
    expect_mask(4'b0000, "R7");
    sup_en_i = '1; live = '1;
    tag = "R3"; strobes(4); expect_mask(4'b0000, "R3");

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule